// File: doc/BRIEF.md
# Digital Gain and Offset Trim Stage

This block sits between the register that holds a converter's raw output code and the path that drives the converter. Whenever a new raw code is written, it applies a user gain trim and a user zero trim, clamps the result to the legal code range, and registers it. The gain trim is an unsigned word whose midpoint means unity. The zero trim is a signed word added after scaling. Both trims are sampled only at the moment of a code write. Changing a trim word therefore leaves the output as it is until the next write.

A resolution select picks 16-bit or 12-bit operation. In 12-bit mode the live data sits in the upper twelve bits of the 16-bit word. The trim arithmetic runs on those twelve bits, with the zero trim counted in 12-bit steps. The low nibble of the result is forced to zero. A calibration enable lets the raw code through untouched, apart from that 12-bit alignment.

Top module: `trim_corrector`

## Requirements
- R1: While reset is asserted and after it is released with no write, `code_out` is 0x0000 and `code_vld` is low.
- R2: A write strobe high in one clock cycle updates `code_out` at the next rising edge and raises `code_vld` for exactly that one following cycle; without a strobe `code_vld` stays low.
- R3: With calibration on in 16-bit mode, the scaled value is floor(code × (32768 + gain) / 65536); a gain of 0x8000 returns the code unchanged.
- R4: A gain of 0x0000 halves the code, rounding down (0x1234 becomes 0x091A); 0xFFFF scales by just under 1.5.
- R5: The zero trim is a 16-bit twos-complement value added to the scaled code, so 0x0005 adds 5 and 0xFFFF subtracts 1.
- R6: A sum above the top code clamps to 0xFFFF (0x0FFF data in 12-bit mode).
- R7: A sum below zero clamps to 0x0000.
- R8: With calibration off, 16-bit mode passes the raw code to the output unchanged.
- R9: Changing the gain trim, zero trim, enable or mode without a write leaves `code_out` unchanged and `code_vld` low; the next write uses the new values.
- R10: In 12-bit mode (`narrow_mode` = 1) the data is `code_in[15:4]`. The scale and zero trim act on that 12-bit value, with the zero trim in 12-bit steps. The result is clamped to 0..0xFFF and returned in `code_out[15:4]`, and `code_out[3:0]` is always 0, with calibration on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_wr | input | 1 | Write strobe for a new raw code |
| code_in | input | 16 | Raw unsigned converter code |
| gain_trim | input | 16 | Unsigned gain trim, 0x8000 = unity |
| zero_trim | input | 16 | Twos-complement zero trim |
| cal_en | input | 1 | 1 = apply trims, 0 = pass raw code |
| narrow_mode | input | 1 | 1 = 12-bit data in bits 15:4 |
| code_out | output | 16 | Corrected, clamped code |
| code_vld | output | 1 | One-cycle pulse when `code_out` has been updated |

## Verification
The bench drives both clamp edges: full-scale codes with maximum gain and a positive trim, and small codes with a negative trim. A design with a too-narrow or unsigned intermediate would wrap there instead of clamping. It also changes the trim words between writes and watches the output. A design that recomputed combinationally from live trims would move without a write. In 12-bit mode it checks that the zero trim counts in 12-bit steps and that the low nibble stays clear in bypass. A design that ran the arithmetic on the raw 16-bit word would leak low bits or be off by a factor of sixteen.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic {
    RES_WIDE   = 1'b0,
    RES_NARROW = 1'b1
  } res_mode_e;

  // signed sum width that holds a scaled value of sw bits and a zero word of zw bits
  function automatic int sum_width(input int sw, input int zw);
    return ((sw > zw) ? sw : zw) + 2;
  endfunction

endpackage

// File: rtl/trim_scale.sv
// Multiplies a code by (2^(GAIN_W-1) + gain) and drops GAIN_W fraction bits.
module trim_scale #(
  parameter int CODE_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [CODE_W:0]   scaled_o
);
  localparam int FACT_W = GAIN_W + 1;
  localparam int PROD_W = CODE_W + FACT_W;
  localparam logic [FACT_W-1:0] UNITY_HALF = {2'b01, {(GAIN_W-1){1'b0}}};

  logic [FACT_W-1:0] factor;
  logic [PROD_W-1:0] product;

  always_comb begin
    factor   = {1'b0, gain_i} + UNITY_HALF;
    product  = PROD_W'(code_i) * PROD_W'(factor);
    scaled_o = product[PROD_W-1:GAIN_W];
  end

endmodule

// File: rtl/trim_clamp.sv
// Adds the signed zero word to the scaled value and clamps to 0 .. 2^CODE_W-1.
module trim_clamp #(
  parameter int CODE_W = 16,
  parameter int ZERO_W = 16
) (
  input  logic [CODE_W:0]   scaled_i,
  input  logic [ZERO_W-1:0] zero_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int SUM_W = trim_pkg::sum_width(CODE_W + 1, ZERO_W);
  localparam logic signed [SUM_W-1:0] TOP_CODE =
    {{(SUM_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic signed [SUM_W-1:0] scaled_s;
  logic signed [SUM_W-1:0] zero_s;
  logic signed [SUM_W-1:0] sum_s;

  always_comb begin
    scaled_s = $signed({{(SUM_W-CODE_W-1){1'b0}}, scaled_i});
    zero_s   = SUM_W'($signed(zero_i));
    sum_s    = scaled_s + zero_s;
    if (sum_s < 0) begin
      code_o = '0;
    end else if (sum_s > TOP_CODE) begin
      code_o = '1;
    end else begin
      code_o = sum_s[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/trim_lane.sv
// One full correction lane for a given data width.
module trim_lane #(
  parameter int CODE_W = 16,
  parameter int GAIN_W = 16,
  parameter int ZERO_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [ZERO_W-1:0] zero_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W:0] scaled;

  trim_scale #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_scale (
    .code_i   (code_i),
    .gain_i   (gain_i),
    .scaled_o (scaled)
  );

  trim_clamp #(.CODE_W(CODE_W), .ZERO_W(ZERO_W)) u_clamp (
    .scaled_i (scaled),
    .zero_i   (zero_i),
    .code_o   (code_o)
  );

endmodule

// File: rtl/trim_corrector.sv
module trim_corrector #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 12,
  parameter int GAIN_W   = 16,
  parameter int ZERO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [DATA_W-1:0] code_in,
  input  logic [GAIN_W-1:0] gain_trim,
  input  logic [ZERO_W-1:0] zero_trim,
  input  logic              cal_en,
  input  logic              narrow_mode,
  output logic [DATA_W-1:0] code_out,
  output logic              code_vld
);
  import trim_pkg::*;

  localparam int PAD_W     = DATA_W - NARROW_W;
  localparam int NUM_LANES = 2;
  localparam int LANE_WIDE   = 0;
  localparam int LANE_NARROW = 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // lanes: one at full width, one at reduced width on the upper bits
  logic [DATA_W-1:0] lane_out [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == LANE_WIDE) ? DATA_W : NARROW_W;
    logic [LW-1:0] lane_res;

    trim_lane #(.CODE_W(LW), .GAIN_W(GAIN_W), .ZERO_W(ZERO_W)) u_lane (
      .code_i (code_in[DATA_W-1 -: LW]),
      .gain_i (gain_trim),
      .zero_i (zero_trim),
      .code_o (lane_res)
    );

    if (LW == DATA_W) begin : g_full
      assign lane_out[g] = lane_res;
    end else begin : g_pad
      assign lane_out[g] = {lane_res, {(DATA_W-LW){1'b0}}};
    end
  end

  // next-state selection
  res_mode_e         res_mode;
  logic [DATA_W-1:0] raw_aligned;
  logic [DATA_W-1:0] result_nxt;
  logic [DATA_W-1:0] code_out_nxt;
  logic              code_vld_nxt;
  logic              out_en;

  always_comb begin
    res_mode    = narrow_mode ? RES_NARROW : RES_WIDE;
    raw_aligned = (res_mode == RES_NARROW)
                  ? {code_in[DATA_W-1:PAD_W], {PAD_W{1'b0}}}
                  : code_in;
    if (!cal_en) begin
      result_nxt = raw_aligned;
    end else if (res_mode == RES_NARROW) begin
      result_nxt = lane_out[LANE_NARROW];
    end else begin
      result_nxt = lane_out[LANE_WIDE];
    end
    out_en       = code_wr;
    code_out_nxt = out_en ? result_nxt : code_out;
    code_vld_nxt = code_wr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      code_out <= '0;
      code_vld <= 1'b0;
    end else begin
      if (out_en) begin
        code_out <= code_out_nxt;
      end
      code_vld <= code_vld_nxt;
    end
  end

endmodule

// File: rtl/trim_corrector_chk.sv
module trim_corrector_chk #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 12
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              code_wr,
  input logic [DATA_W-1:0] code_in,
  input logic              cal_en,
  input logic              narrow_mode,
  input logic [DATA_W-1:0] code_out,
  input logic              code_vld
);
  localparam int PAD_W = DATA_W - NARROW_W;

  assert_vld_follows_wr_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    code_wr |=> code_vld);

  assert_no_vld_without_wr_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !code_wr |=> !code_vld);

  assert_hold_without_wr_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !code_wr |=> $stable(code_out));

  assert_bypass_wide_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (code_wr && !cal_en && !narrow_mode) |=> (code_out == $past(code_in)));

  assert_narrow_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (code_wr && narrow_mode) |=> (code_out[PAD_W-1:0] == '0));

endmodule

bind trim_corrector trim_corrector_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .code_wr     (code_wr),
  .code_in     (code_in),
  .cal_en      (cal_en),
  .narrow_mode (narrow_mode),
  .code_out    (code_out),
  .code_vld    (code_vld)
);

// File: tb/tb_trim_corrector.sv
module tb_trim_corrector;

  logic        clk;
  logic        rst_n;
  logic        code_wr;
  logic [15:0] code_in;
  logic [15:0] gain_trim;
  logic [15:0] zero_trim;
  logic        cal_en;
  logic        narrow_mode;
  logic [15:0] code_out;
  logic        code_vld;

  int n_checks;
  int n_fail;
  bit done;

  trim_corrector dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_wr     (code_wr),
    .code_in     (code_in),
    .gain_trim   (gain_trim),
    .zero_trim   (zero_trim),
    .cal_en      (cal_en),
    .narrow_mode (narrow_mode),
    .code_out    (code_out),
    .code_vld    (code_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected code from the requirement text (R3..R8, R10)
  function automatic logic [15:0] expect_code(input logic [15:0] c, input logic [15:0] g,
                                               input logic [15:0] z, input bit en, input bit nar);
    longint d, v, top;
    d   = nar ? longint'(c[15:4]) : longint'(c);
    top = nar ? 4095 : 65535;
    if (!en) begin
      v = d;
    end else begin
      v = (d * (32768 + longint'(g))) / 65536 + longint'($signed(z));
      if (v < 0) v = 0;
      if (v > top) v = top;
    end
    return nar ? 16'(v << 4) : 16'(v);
  endfunction

  task automatic write_code(input logic [15:0] c, input logic [15:0] g, input logic [15:0] z,
                            input bit en, input bit nar);
    @(negedge clk);
    code_in = c; gain_trim = g; zero_trim = z; cal_en = en; narrow_mode = nar;
    code_wr = 1'b1;
    @(negedge clk);
    code_wr = 1'b0;
  endtask

  task automatic wr_check(input string req, input logic [15:0] c, input logic [15:0] g,
                          input logic [15:0] z, input bit en, input bit nar,
                          input logic [15:0] exp);
    write_code(c, g, z, en, nar);
    check({req, " vld"}, 32'(code_vld), 32'd1);
    check(req, 32'(code_out), 32'(exp));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; code_wr = 1'b0; code_in = '0; gain_trim = '0; zero_trim = '0;
    cal_en = 1'b0; narrow_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out in reset", 32'(code_out), 32'h0);
    check("R1 vld in reset", 32'(code_vld), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out after reset", 32'(code_out), 32'h0);
    check("R1 vld after reset", 32'(code_vld), 32'h0);
  endtask

  task automatic t_pulse;
    write_code(16'h0100, 16'h8000, 16'h0000, 1'b1, 1'b0);
    check("R2 vld one cycle after write", 32'(code_vld), 32'd1);
    check("R2 data after write", 32'(code_out), 32'h0100);
    @(negedge clk);
    check("R2 vld drops", 32'(code_vld), 32'd0);
  endtask

  task automatic t_gain;
    wr_check("R3 unity", 16'h1234, 16'h8000, 16'h0000, 1'b1, 1'b0, 16'h1234);
    wr_check("R3 quarter up", 16'h4000, 16'hC000, 16'h0000, 1'b1, 1'b0,
             expect_code(16'h4000, 16'hC000, 16'h0, 1'b1, 1'b0));
    wr_check("R4 half gain", 16'h1234, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h091A);
    wr_check("R4 odd half", 16'h0003, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0001);
    wr_check("R4 max gain", 16'h8000, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'hBFFF);
  endtask

  task automatic t_zero;
    wr_check("R5 plus five", 16'h1234, 16'h8000, 16'h0005, 1'b1, 1'b0, 16'h1239);
    wr_check("R5 minus one", 16'h1234, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 16'h1233);
    wr_check("R5 with gain", 16'h2000, 16'h0000, 16'hFF00, 1'b1, 1'b0, 16'h0F00);
  endtask

  task automatic t_sat;
    wr_check("R6 high max gain", 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 16'hFFFF);
    wr_check("R6 high offset", 16'hFFF0, 16'h8000, 16'h7FFF, 1'b1, 1'b0, 16'hFFFF);
    wr_check("R6 edge exact", 16'hFFF0, 16'h8000, 16'h000F, 1'b1, 1'b0, 16'hFFFF);
    wr_check("R7 low", 16'h0010, 16'h8000, 16'hFFEF, 1'b1, 1'b0, 16'h0000);
    wr_check("R7 most negative", 16'h7FFF, 16'h8000, 16'h8000, 1'b1, 1'b0, 16'h0000);
    wr_check("R7 to zero exact", 16'h0010, 16'h8000, 16'hFFF0, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_bypass;
    wr_check("R8 raw pass", 16'hA5C3, 16'h0000, 16'h7FFF, 1'b0, 1'b0, 16'hA5C3);
    wr_check("R8 raw full", 16'hFFFF, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 16'hFFFF);
  endtask

  task automatic t_hold;
    wr_check("R9 base", 16'h1000, 16'h8000, 16'h0000, 1'b1, 1'b0, 16'h1000);
    @(negedge clk);
    gain_trim = 16'h0000; zero_trim = 16'h0100; narrow_mode = 1'b1; cal_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 hold data", 32'(code_out), 32'h1000);
    check("R9 no vld", 32'(code_vld), 32'd0);
    wr_check("R9 new trim applies", 16'h1000, 16'h0000, 16'h0100, 1'b1, 1'b0, 16'h0900);
  endtask

  task automatic t_narrow;
    wr_check("R10 unity", 16'hABC5, 16'h8000, 16'h0000, 1'b1, 1'b1, 16'hABC0);
    wr_check("R10 zero step", 16'hABC5, 16'h8000, 16'h0003, 1'b1, 1'b1, 16'hABF0);
    wr_check("R10 half", 16'h2468, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h1230);
    wr_check("R10 clamp high", 16'hF000, 16'h8000, 16'h1388, 1'b1, 1'b1, 16'hFFF0);
    wr_check("R10 clamp low", 16'h0020, 16'h8000, 16'hFFFD, 1'b1, 1'b1, 16'h0000);
    wr_check("R10 bypass nibble", 16'hABCF, 16'h1234, 16'h0042, 1'b0, 1'b1, 16'hABC0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] c, g, z;
      c = 16'(i * 16'h0AF3 + 16'h0111);
      g = 16'(i * 16'h1B37);
      z = 16'(i * 16'h2E11 - 16'h4000);
      wr_check("R3 R5 sweep", c, g, z, 1'b1, i[0], expect_code(c, g, z, 1'b1, i[0]));
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_pulse();
    t_gain();
    t_zero();
    t_sat();
    t_bypass();
    t_hold();
    t_narrow();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule